// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block raises interrupts for one bank of general-purpose pins. It takes pin levels that are already synchronized to its clock. It keeps the previous sample of each pin, so it can detect edges. Each pin has its own trigger condition, chosen by three configuration bits: type, polarity and any-edge. Together they select rising edge, falling edge, both edges, active-high level or active-low level.

A qualifying event sets that pin's pending bit in a status register. Software clears pending bits by writing ones to them. A per-pin mask decides which pending bits drive the bank's single registered interrupt line. The mask cannot be written directly. One write port clears mask bits (enabling pins) and another sets them (disabling pins). A read port shows the mask, the status and the three configuration registers.

Register access is word-indexed. The index values are listed in the requirements. Reads are combinational from `rdAddr`. Writes take effect at the clock edge on which `wrEn` is high.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is held, the mask reads all ones, the status, type, polarity and any-edge registers read zero, and `irqOut` is 0.
- R2: A write to index 1 (enable) clears each mask bit whose data bit is 1. Mask bits written with 0 keep their value.
- R3: A write to index 2 (disable) sets each mask bit whose data bit is 1. Mask bits written with 0 keep their value. Writing all ones disables every pin.
- R4: Index 0 reads the mask. A write to index 0 leaves the mask unchanged.
- R5: Index 4 (type), index 5 (polarity) and index 6 (any-edge) are read/write and read back the last value written.
- R6: With type=1, polarity=1 and any-edge=0, a pin whose new sample is 1 and whose previous sample was 0 sets its status bit at that clock edge.
- R7: With type=1, polarity=0 and any-edge=0, a pin that goes from 1 to 0 sets its status bit.
- R8: With type=1 and any-edge=1, either transition sets the status bit, whatever the polarity bit holds.
- R9: With type=0, the status bit is set on every edge while the pin equals the polarity bit, and the any-edge bit is ignored. A clear therefore has no effect while the level stays active.
- R10: A write to index 3 clears each status bit whose data bit is 1. Bits written with 0 are unaffected. If an event occurs on a bit in the same cycle as its clear, the bit stays set.
- R11: An edge-triggered status bit stays set, without further events, until it is cleared.
- R12: `irqOut` is a register. It equals the OR over all pins of (status AND NOT mask), as those registers stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pinIn | input | NUM_PINS | Synchronized pin levels |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register index for the write |
| wrData | input | NUM_PINS | Write data |
| rdAddr | input | 3 | Register index for the read |
| rdData | output | NUM_PINS | Read data (combinational) |
| irqOut | output | 1 | Combined bank interrupt (registered) |

## Verification
The bench builds the block with its default width of 32 pins. At that width, every trigger mode can be applied to different bit lanes at once, for example mixed type, polarity and any-edge patterns across the upper and lower halves of the bank. The full-width all-ones disable write and the all-ones status clear are also covered. The vector loop changes the pins in the same cycle as a full status clear. As a result, each vector also exercises the rule that a new event wins over a clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_MASK = 3'd0,
    REG_EN   = 3'd1,
    REG_DIS  = 3'd2,
    REG_STAT = 3'd3,
    REG_TYPE = 3'd4,
    REG_POL  = 3'd5,
    REG_ANY  = 3'd6
  } regIdx_e;

  typedef struct packed {
    logic maskSet;
    logic maskClr;
    logic statusClr;
    logic typeWr;
    logic polWr;
    logic anyWr;
  } strobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  logic [REG_IDX_W-1:0] wrAddr,
  input  logic [REG_IDX_W-1:0] rdAddr,
  input  logic [NUM_PINS-1:0]  maskVal,
  input  logic [NUM_PINS-1:0]  statusVal,
  input  logic [NUM_PINS-1:0]  typeVal,
  input  logic [NUM_PINS-1:0]  polVal,
  input  logic [NUM_PINS-1:0]  anyVal,
  output strobe_t              strb,
  output logic [NUM_PINS-1:0]  rdData
);
  // Write decode: at most one strobe per write; index 0 is read-only.
  always_comb begin
    strb           = '0;
    strb.maskClr   = wrEn && (wrAddr == REG_EN);
    strb.maskSet   = wrEn && (wrAddr == REG_DIS);
    strb.statusClr = wrEn && (wrAddr == REG_STAT);
    strb.typeWr    = wrEn && (wrAddr == REG_TYPE);
    strb.polWr     = wrEn && (wrAddr == REG_POL);
    strb.anyWr     = wrEn && (wrAddr == REG_ANY);
  end

  always_comb begin
    case (rdAddr)
      REG_MASK: rdData = maskVal;
      REG_STAT: rdData = statusVal;
      REG_TYPE: rdData = typeVal;
      REG_POL:  rdData = polVal;
      REG_ANY:  rdData = anyVal;
      default:  rdData = '0;
    endcase
  end

  // R4: a write to the mask view index raises no strobe at all
  assert_mask_view_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr == REG_MASK) |-> (strb == '0));
  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));
endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] wrData,
  input  strobe_t             strb,
  output logic [NUM_PINS-1:0] maskR,
  output logic [NUM_PINS-1:0] statusR,
  output logic [NUM_PINS-1:0] typeR,
  output logic [NUM_PINS-1:0] polR,
  output logic [NUM_PINS-1:0] anyR,
  output logic                irqOut
);
  logic [NUM_PINS-1:0] pinPrev;
  logic [NUM_PINS-1:0] evt;
  logic [NUM_PINS-1:0] clrMask;

  // Per-pin trigger decode
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic rise, fall, edgeHit, levelHit;
    assign rise     = pinIn[i] & ~pinPrev[i];
    assign fall     = ~pinIn[i] & pinPrev[i];
    assign edgeHit  = anyR[i] ? (rise | fall) : (polR[i] ? rise : fall);
    assign levelHit = (pinIn[i] == polR[i]);
    assign evt[i]   = typeR[i] ? edgeHit : levelHit;
  end

  assign clrMask = strb.statusClr ? wrData : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pinPrev <= '0;
      maskR   <= '1;
      statusR <= '0;
      typeR   <= '0;
      polR    <= '0;
      anyR    <= '0;
      irqOut  <= 1'b0;
    end else begin
      pinPrev <= pinIn;
      if (strb.maskSet)      maskR <= maskR | wrData;
      else if (strb.maskClr) maskR <= maskR & ~wrData;
      if (strb.typeWr) typeR <= wrData;
      if (strb.polWr)  polR  <= wrData;
      if (strb.anyWr)  anyR  <= wrData;
      statusR <= (statusR & ~clrMask) | evt;
      irqOut  <= |(statusR & ~maskR);
    end
  end

  assert_en_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.maskClr |=> ((maskR & $past(wrData)) == '0));
  assert_en_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.maskClr |=> ((maskR & ~$past(wrData)) == ($past(maskR) & ~$past(wrData))));
  assert_dis_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.maskSet |=> ((maskR & $past(wrData)) == $past(wrData)));
  assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.maskSet || strb.maskClr) |=> $stable(maskR));
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((statusR & $past(evt)) == $past(evt)));
  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strb.statusClr |=> ((statusR & $past(wrData & ~evt)) == '0));
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.statusClr |=> ((statusR & $past(statusR)) == $past(statusR)));
  assert_irq_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> ($past(statusR & ~maskR) != '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PINS-1:0]  pinIn,
  input  logic                 wrEn,
  input  logic [REG_IDX_W-1:0] wrAddr,
  input  logic [NUM_PINS-1:0]  wrData,
  input  logic [REG_IDX_W-1:0] rdAddr,
  output logic [NUM_PINS-1:0]  rdData,
  output logic                 irqOut
);
  strobe_t             strb;
  logic [NUM_PINS-1:0] maskR, statusR, typeR, polR, anyR;

  gpio_irq_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .maskVal(maskR), .statusVal(statusR), .typeVal(typeR), .polVal(polR),
    .anyVal(anyR), .strb(strb), .rdData(rdData)
  );

  gpio_irq_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .wrData(wrData), .strb(strb),
    .maskR(maskR), .statusR(statusR), .typeR(typeR), .polR(polR),
    .anyR(anyR), .irqOut(irqOut)
  );
endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam logic [2:0] I_MASK = 3'd0, I_EN = 3'd1, I_DIS = 3'd2,
    I_STAT = 3'd3, I_TYPE = 3'd4, I_POL = 3'd5, I_ANY = 3'd6;

  // {type, pol, any, before, after, enable}
  localparam int NVEC = 6;
  localparam logic [6*W-1:0] VEC [NVEC] = '{
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h0000FFFF, 32'h00FF00FF, 32'h00010000},
    {32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h0000FFFF, 32'h00FF00FF, 32'h00FF0000},
    {32'hFFFFFFFF, 32'h5555AAAA, 32'hFFFFFFFF, 32'h0000FFFF, 32'h00FF00FF, 32'hFFFFFFFF},
    {32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0000FFFF, 32'h00FF00FF, 32'h00000000},
    {32'h00000000, 32'h00000000, 32'h00000000, 32'hFFFF0000, 32'h00FF00FF, 32'h000000F0},
    {32'hFFFF0000, 32'h0F0F0F0F, 32'h00FF00FF, 32'h12345678, 32'h87654321, 32'hFFFFFFFF}
  };
  localparam string VREQ [NVEC] = '{"R6", "R7", "R8", "R9", "R9", "R8"};

  logic clk = 0, rst_n = 0, wrEn = 0, irqOut;
  logic [2:0] wrAddr = '0, rdAddr = '0;
  logic [W-1:0] pinIn = '0, wrData = '0, rdData;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(W)) i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut)
  );

  function automatic logic [W-1:0] model(logic [W-1:0] t, p, a, b, f);
    logic [W-1:0] rise, fall, edg, lvl;
    rise = f & ~b;
    fall = ~f & b;
    edg  = (a & (rise | fall)) | (~a & p & rise) | (~a & ~p & fall);
    lvl  = ~(f ^ p);
    return (t & edg) | (~t & lvl);
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] idx, logic [W-1:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = idx; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic rd(logic [2:0] idx, output logic [W-1:0] v);
    rdAddr = idx;
    #1;
    v = rdData;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] v;
    // R1: reset state
    repeat (3) @(negedge clk);
    rd(I_MASK, v); check("R1 mask", v, '1);
    rd(I_STAT, v); check("R1 status", v, '0);
    rd(I_TYPE, v); check("R1 type", v, '0);
    rd(I_POL, v);  check("R1 pol", v, '0);
    rd(I_ANY, v);  check("R1 any", v, '0);
    check("R1 irq", {31'b0, irqOut}, '0);
    rst_n = 1;

    // Table of trigger vectors; pins change in the cycle of a full clear (R10 set wins)
    for (int k = 0; k < NVEC; k++) begin
      logic [W-1:0] t, p, a, b, f, en, exp;
      {t, p, a, b, f, en} = VEC[k];
      wr(I_DIS, '1);
      wr(I_EN, en);
      wr(I_TYPE, t);
      wr(I_POL, p);
      wr(I_ANY, a);
      pinIn = b;
      repeat (2) @(negedge clk);
      pinIn = f; wrEn = 1; wrAddr = I_STAT; wrData = '1;
      @(negedge clk);
      wrEn = 0;
      exp = model(t, p, a, b, f);
      rd(I_STAT, v); check(VREQ[k], v, exp);
      @(negedge clk);
      check("R12 irq vector", {31'b0, irqOut}, {31'b0, |(exp & en)});
    end

    // R4, R2, R3 mask ports
    wr(I_DIS, '1);
    wr(I_MASK, '0);
    rd(I_MASK, v); check("R4 mask write ignored", v, '1);
    wr(I_EN, 32'h0000000F);
    rd(I_MASK, v); check("R2 enable clears", v, 32'hFFFFFFF0);
    wr(I_EN, '0);
    rd(I_MASK, v); check("R2 zero bits no effect", v, 32'hFFFFFFF0);
    wr(I_DIS, 32'h00000003);
    rd(I_MASK, v); check("R3 disable sets", v, 32'hFFFFFFF3);
    wr(I_DIS, '0);
    rd(I_MASK, v); check("R3 zero bits no effect", v, 32'hFFFFFFF3);

    // R5 readback
    wr(I_TYPE, 32'hA5A5C3C3); rd(I_TYPE, v); check("R5 type", v, 32'hA5A5C3C3);
    wr(I_POL, 32'h0F0F1234);  rd(I_POL, v);  check("R5 pol", v, 32'h0F0F1234);
    wr(I_ANY, 32'h600DF00D);  rd(I_ANY, v);  check("R5 any", v, 32'h600DF00D);

    // R11 sticky edge, R10 partial clear, R12 irq timing
    wr(I_TYPE, '1); wr(I_POL, '1); wr(I_ANY, '0);
    pinIn = '0;
    repeat (2) @(negedge clk);
    wr(I_STAT, '1);
    wr(I_EN, '1);
    pinIn = 32'h0000000F;
    repeat (5) @(negedge clk);
    rd(I_STAT, v); check("R11 sticky", v, 32'h0000000F);
    check("R12 irq set", {31'b0, irqOut}, 32'd1);
    wr(I_STAT, 32'h00000003);
    rd(I_STAT, v); check("R10 partial clear", v, 32'h0000000C);
    wr(I_STAT, '0);
    rd(I_STAT, v); check("R10 zero write", v, 32'h0000000C);
    wr(I_STAT, '1);
    rd(I_STAT, v); check("R10 full clear", v, '0);
    check("R12 irq lags one cycle", {31'b0, irqOut}, 32'd1);
    @(negedge clk);
    check("R12 irq drops", {31'b0, irqOut}, '0);

    // R9 level: clear ineffective while active, any-edge ignored
    pinIn = 32'h00000001;
    wr(I_ANY, '1);
    wr(I_TYPE, '0);
    repeat (2) @(negedge clk);
    wr(I_STAT, '1);
    rd(I_STAT, v); check("R9 clear while active", v, 32'h00000001);
    pinIn = '0;
    @(negedge clk);
    wr(I_STAT, '1);
    rd(I_STAT, v); check("R9 clear after release", v, '0);

    finish_run();
  end
endmodule